// File: doc/BRIEF.md
# PHY Control-Port Handshake Sequencer

This block performs one register read or one register write on a PHY whose 16-bit registers are not memory-mapped. The PHY is reached through a single control word and a single status word. The control word holds a 16-bit address/data field and four strobes. Every strobe change is confirmed by a four-phase exchange on one acknowledge bit. The block splits an access into phases. First the address is captured. A write then captures its data and commits. A read raises its read strobe and takes the returned value from the status word. Each phase raises a strobe, waits for the acknowledge to rise, drops the strobe and waits for the acknowledge to fall.

On the user side, a request carries a direction flag, an address and write data. It is accepted only while the sequencer is idle. When the access ends, a one-cycle done pulse comes back with an error flag and, for reads, the data. Every acknowledge wait is bounded. The acknowledge is sampled a fixed number of times at a programmable spacing. If the expected level never appears, the access is abandoned: the control word returns to zero and the error flag is raised.

Top module: `phy_ctl_seq`

## Requirements
- R1: The control word places the address/data field at bits 15:0, capture-address at bit 16, capture-data at bit 17, write at bit 18 and read at bit 19. At most one strobe is high at any time, and the word is zero whenever the block is idle.
- R2: `req_ready` is high only in idle. A request is taken on a cycle with `req_valid` and `req_ready` both high, and its inputs are registered then. Later changes to the request inputs, and requests raised while busy, have no effect.
- R3: The address phase drives the address with all strobes low for one cycle. It then drives address plus capture-address and waits for the acknowledge high. It then drives the address alone and waits for the acknowledge low.
- R4: A write follows with a data phase. The data is driven with strobes low for one cycle. Then data plus capture-data is driven and the block waits for the acknowledge high. Then the data alone is driven and the block waits for the acknowledge low.
- R5: A write then drives the write strobe alone, with the field zero, and waits for the acknowledge high. Next it drives the data alone and waits for the acknowledge low. Finally the word returns to zero as done is raised.
- R6: A read follows the address phase by driving the read strobe alone and waiting for the acknowledge high. On the sample that sees it high, status bits 15:0 are latched into `rd_data`. The word then goes to zero and the block waits for the acknowledge low before done.
- R7: Each wait samples the acknowledge (status bit 16) in its first cycle and then every `POLL_GAP` cycles, at most `MAX_POLLS` times. A wait whose k-th sample matches leaves the phase on the next cycle, so a phase costs (k-1)*`POLL_GAP`+1 cycles.
- R8: If the last permitted sample still misses, the control word goes to zero and done is raised with `err` high. The remaining phases are skipped and the block is ready again. `err` is low with the done of a successful access and stays valid until the next acceptance.
- R9: `done` is high for exactly one cycle per accepted request. `rd_data` keeps its value until a later read latches new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | DW | PHY register address |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Access ended by acknowledge timeout |
| rd_data | output | DW | Last data read from the PHY |
| phy_ctl | output | DW+4 | Control word: field, then four strobes |
| phy_stat | input | DW+1 | Status word: returned data below, acknowledge on top |

## Verification
The acknowledge arriving and the wait running out can fall on the same sample: the last permitted poll of a wait. The bench's PHY model can hold its acknowledge back for a chosen number of cycles after a strobe rises. With the default spacing of 4 cycles and 10 polls, a delay of 36 cycles puts the acknowledge exactly on the tenth sample, and a delay of 37 puts it one cycle after. The first case must finish cleanly at the latency computed from R7. The second must end as a timeout with `err` high, after 38 cycles, with the later phases absent from the control-word trace.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

   // strobe slots above the address/data field
   localparam int STB_CAP_ADR = 0;
   localparam int STB_CAP_DAT = 1;
   localparam int STB_WRITE   = 2;
   localparam int STB_READ    = 3;
   localparam int NUM_STB     = 4;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADR_SET,
      ST_ADR_CAP,
      ST_ADR_REL,
      ST_DAT_SET,
      ST_DAT_CAP,
      ST_DAT_REL,
      ST_CMT_GO,
      ST_CMT_REL,
      ST_RD_GO,
      ST_RD_REL
   } step_e;

   // steps that hold until the acknowledge reaches a level
   function automatic logic step_waits(step_e s);
      return (s == ST_ADR_CAP) || (s == ST_ADR_REL) ||
             (s == ST_DAT_CAP) || (s == ST_DAT_REL) ||
             (s == ST_CMT_GO)  || (s == ST_CMT_REL) ||
             (s == ST_RD_GO)   || (s == ST_RD_REL);
   endfunction

   // acknowledge level each waiting step expects
   function automatic logic step_want(step_e s);
      return (s == ST_ADR_CAP) || (s == ST_DAT_CAP) ||
             (s == ST_CMT_GO)  || (s == ST_RD_GO);
   endfunction

endpackage

// File: rtl/phy_ctl_encoder.sv
module phy_ctl_encoder
   import phy_seq_pkg::*;
#(
   parameter int DW = 16
) (
   input  step_e                 step,
   input  logic [DW-1:0]         addr,
   input  logic [DW-1:0]         data,
   output logic [DW+NUM_STB-1:0] word
);

   localparam int CW = DW + NUM_STB;

   logic [DW-1:0]      fld;
   logic [NUM_STB-1:0] stb;

   always_comb begin
      fld = '0;
      stb = '0;
      unique case (step)
         ST_ADR_SET, ST_ADR_REL: fld = addr;
         ST_ADR_CAP: begin
            fld              = addr;
            stb[STB_CAP_ADR] = 1'b1;
         end
         ST_DAT_SET, ST_DAT_REL, ST_CMT_REL: fld = data;
         ST_DAT_CAP: begin
            fld              = data;
            stb[STB_CAP_DAT] = 1'b1;
         end
         ST_CMT_GO: stb[STB_WRITE] = 1'b1;
         ST_RD_GO:  stb[STB_READ]  = 1'b1;
         default: begin
            fld = '0;
            stb = '0;
         end
      endcase
   end

   assign word[CW-1:DW] = stb;
   assign word[DW-1:0]  = fld;

endmodule

// File: rtl/phy_ack_poller.sv
module phy_ack_poller #(
   parameter int MAX_POLLS = 10,
   parameter int POLL_GAP  = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic active,
   input  logic ack,
   input  logic want,
   output logic hit,
   output logic expire
);

   localparam int PW = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
   localparam logic [PW-1:0] LAST_POLL = PW'(MAX_POLLS - 1);

   logic [PW-1:0] polls;
   logic          gap_zero;
   logic          sample;

   assign sample = active && gap_zero;
   assign hit    = sample && (ack == want);
   assign expire = sample && (ack != want) && (polls == LAST_POLL);

   always_ff @(posedge clk) begin
      if (!rst_n || arm) begin
         polls <= '0;
      end else if (sample && (polls != LAST_POLL)) begin
         polls <= polls + 1'b1;
      end
   end

   generate
      if (POLL_GAP > 1) begin : gen_spaced
         localparam int GW = $clog2(POLL_GAP);
         localparam logic [GW-1:0] GAP_RELOAD = GW'(POLL_GAP - 1);
         logic [GW-1:0] gap;
         always_ff @(posedge clk) begin
            if (!rst_n || arm) begin
               gap <= '0;
            end else if (active) begin
               if (gap == '0) begin
                  gap <= GAP_RELOAD;
               end else begin
                  gap <= gap - 1'b1;
               end
            end
         end
         assign gap_zero = (gap == '0);
      end else begin : gen_every_cycle
         assign gap_zero = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/phy_step_fsm.sv
module phy_step_fsm
   import phy_seq_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          req_write,
   input  logic [DW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   input  logic          hit,
   input  logic          expire,
   input  logic [DW-1:0] stat_data,
   output step_e         nxt_step,
   output logic          arm,
   output logic          active,
   output logic          want,
   output logic [DW-1:0] fld_addr,
   output logic [DW-1:0] fld_data,
   output logic          ready,
   output logic          done,
   output logic          err,
   output logic [DW-1:0] rd_data
);

   step_e         state;
   step_e         nxt;
   logic          finish;
   logic          fail;
   logic          accept;
   logic          wr_q;
   logic [DW-1:0] addr_q;
   logic [DW-1:0] data_q;

   assign ready  = (state == ST_IDLE);
   assign accept = ready && req_valid;
   assign active = step_waits(state);
   assign want   = step_want(state);
   assign arm    = (nxt != state) && step_waits(nxt);

   assign nxt_step = nxt;
   assign fld_addr = ready ? req_addr : addr_q;
   assign fld_data = data_q;

   always_comb begin
      nxt    = state;
      finish = 1'b0;
      fail   = 1'b0;
      unique case (state)
         ST_IDLE:    if (req_valid) nxt = ST_ADR_SET;
         ST_ADR_SET: nxt = ST_ADR_CAP;
         ST_ADR_CAP: if (hit) nxt = ST_ADR_REL;
         ST_ADR_REL: if (hit) nxt = wr_q ? ST_DAT_SET : ST_RD_GO;
         ST_DAT_SET: nxt = ST_DAT_CAP;
         ST_DAT_CAP: if (hit) nxt = ST_DAT_REL;
         ST_DAT_REL: if (hit) nxt = ST_CMT_GO;
         ST_CMT_GO:  if (hit) nxt = ST_CMT_REL;
         ST_CMT_REL: if (hit) begin
            nxt    = ST_IDLE;
            finish = 1'b1;
         end
         ST_RD_GO:   if (hit) nxt = ST_RD_REL;
         ST_RD_REL:  if (hit) begin
            nxt    = ST_IDLE;
            finish = 1'b1;
         end
         default:    nxt = ST_IDLE;
      endcase
      if (expire) begin
         nxt    = ST_IDLE;
         finish = 1'b0;
         fail   = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         wr_q    <= 1'b0;
         addr_q  <= '0;
         data_q  <= '0;
         done    <= 1'b0;
         err     <= 1'b0;
         rd_data <= '0;
      end else begin
         state <= nxt;
         done  <= finish || fail;
         if (accept) begin
            wr_q   <= req_write;
            addr_q <= req_addr;
            data_q <= req_wdata;
            err    <= 1'b0;
         end else if (fail) begin
            err <= 1'b1;
         end
         if ((state == ST_RD_GO) && hit) begin
            rd_data <= stat_data;
         end
      end
   end

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9

   AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !ready); // R2

   AST_ERR_ONLY_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> done); // R8

endmodule

// File: rtl/phy_ctl_seq.sv
module phy_ctl_seq
   import phy_seq_pkg::*;
#(
   parameter int DW        = 16,
   parameter int MAX_POLLS = 10,
   parameter int POLL_GAP  = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic                 req_write,
   input  logic [DW-1:0]        req_addr,
   input  logic [DW-1:0]        req_wdata,
   output logic                 req_ready,
   output logic                 done,
   output logic                 err,
   output logic [DW-1:0]        rd_data,
   output logic [DW+NUM_STB-1:0] phy_ctl,
   input  logic [DW:0]          phy_stat
);

   localparam int CW      = DW + NUM_STB;
   localparam int ACK_BIT = DW;

   generate
      if (DW < 1) begin : gen_bad_dw
         $error("phy_ctl_seq: DW must be at least 1");
      end
      if (MAX_POLLS < 1) begin : gen_bad_polls
         $error("phy_ctl_seq: MAX_POLLS must be at least 1");
      end
      if (POLL_GAP < 1) begin : gen_bad_gap
         $error("phy_ctl_seq: POLL_GAP must be at least 1");
      end
   endgenerate

   step_e         nxt_step;
   logic          arm;
   logic          active;
   logic          want;
   logic          hit;
   logic          expire;
   logic [DW-1:0] fld_addr;
   logic [DW-1:0] fld_data;
   logic [CW-1:0] ctl_nxt;
   logic [CW-1:0] ctl_q;

   phy_step_fsm #(.DW(DW)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .hit       (hit),
      .expire    (expire),
      .stat_data (phy_stat[DW-1:0]),
      .nxt_step  (nxt_step),
      .arm       (arm),
      .active    (active),
      .want      (want),
      .fld_addr  (fld_addr),
      .fld_data  (fld_data),
      .ready     (req_ready),
      .done      (done),
      .err       (err),
      .rd_data   (rd_data)
   );

   phy_ack_poller #(.MAX_POLLS(MAX_POLLS), .POLL_GAP(POLL_GAP)) u_poll (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm    (arm),
      .active (active),
      .ack    (phy_stat[ACK_BIT]),
      .want   (want),
      .hit    (hit),
      .expire (expire)
   );

   phy_ctl_encoder #(.DW(DW)) u_enc (
      .step (nxt_step),
      .addr (fld_addr),
      .data (fld_data),
      .word (ctl_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else begin
         ctl_q <= ctl_nxt;
      end
   end

   assign phy_ctl = ctl_q;

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ctl_q[CW-1:DW])); // R1

   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (ctl_q == '0)); // R2

   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctl_q[DW+STB_CAP_ADR]) |-> (ctl_q[DW-1:0] == $past(ctl_q[DW-1:0]))); // R3

   AST_ADDR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ctl_q[DW+STB_CAP_ADR]) && !done) |-> (ctl_q[DW-1:0] == $past(ctl_q[DW-1:0]))); // R3

   AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctl_q[DW+STB_CAP_DAT]) |-> (ctl_q[DW-1:0] == $past(ctl_q[DW-1:0]))); // R4

   AST_STROBE_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q[DW+STB_WRITE] || ctl_q[DW+STB_READ]) |-> (ctl_q[DW-1:0] == '0)); // R5

   AST_ZERO_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (ctl_q == '0)); // R8

endmodule

// File: tb/test_phy_ctl_seq.sv
module test_phy_ctl_seq;

   localparam int CLK_PERIOD = 10;
   localparam int DW   = 16;
   localparam int MAXP = 10;
   localparam int GAP  = 4;
   localparam int CW   = DW + 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [DW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          req_ready;
   logic          done;
   logic          err;
   logic [DW-1:0] rd_data;
   logic [CW-1:0] phy_ctl;
   logic [DW:0]   phy_stat;

   int n_checks = 0;
   int n_errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   phy_ctl_seq #(.DW(DW), .MAX_POLLS(MAXP), .POLL_GAP(GAP)) i_phy_ctl_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .req_ready (req_ready),
      .done      (done),
      .err       (err),
      .rd_data   (rd_data),
      .phy_ctl   (phy_ctl),
      .phy_stat  (phy_stat)
   );

   // ---------------- PHY model ----------------
   int            dly = 2;
   logic          force_hi = 1'b0;
   logic          force_lo = 1'b0;
   int            age;
   logic [CW-1:0] prev_ctl;
   logic [DW-1:0] m_adr;
   logic [DW-1:0] m_dat;
   logic [DW-1:0] m_mem [0:7];
   logic          any_stb;
   logic          ack;

   assign any_stb  = |phy_ctl[CW-1:DW];
   assign ack      = force_hi | (!force_lo && any_stb && (age >= dly));
   assign phy_stat = {ack, m_mem[m_adr[2:0]]};

   always @(posedge clk) begin
      if (!rst_n) begin
         age      <= 0;
         prev_ctl <= '0;
         m_adr    <= '0;
         m_dat    <= '0;
         for (int i = 0; i < 8; i++) m_mem[i] <= '0;
      end else begin
         age      <= any_stb ? age + 1 : 0;
         prev_ctl <= phy_ctl;
         if (phy_ctl[DW] && !prev_ctl[DW]) m_adr <= phy_ctl[DW-1:0];
         if (phy_ctl[DW+1] && !prev_ctl[DW+1]) m_dat <= phy_ctl[DW-1:0];
         if (phy_ctl[DW+2] && !prev_ctl[DW+2]) m_mem[m_adr[2:0]] <= m_dat;
      end
   end

   // ---------------- monitor ----------------
   logic [CW-1:0] trace [0:255];
   int            ntr = 0;
   int            n_done = 0;
   logic [CW-1:0] last_ctl = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (phy_ctl !== last_ctl) begin
            if (ntr < 256) trace[ntr] = phy_ctl;
            ntr = ntr + 1;
            last_ctl = phy_ctl;
         end
         if (done) n_done = n_done + 1;
      end
   end

   function automatic logic [CW-1:0] cw(logic [3:0] stb, logic [DW-1:0] f);
      return {stb, f};
   endfunction

   task automatic chk(input logic cond, input string tag,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!cond) begin
         n_errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic chk_tr(input int idx, input logic [CW-1:0] exp, input string tag);
      logic [CW-1:0] a;
      a = (idx < 256) ? trace[idx] : '1;
      chk(a == exp, tag, 32'(a), 32'(exp));
   endtask

   // one access; cyc = clock edges from acceptance to the edge raising done
   task automatic run(input logic w, input logic [DW-1:0] a, input logic [DW-1:0] d,
                      output int cyc);
      @(negedge clk);
      req_write = w;
      req_addr  = a;
      req_wdata = d;
      req_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      req_addr  = ~a;
      req_wdata = ~d;
      req_write = ~w;
      cyc = 0;
      while (!done && cyc < 3000) begin
         @(posedge clk);
         cyc++;
         @(negedge clk);
      end
      @(negedge clk);
      chk(!done, "R9 done lasts one cycle", 32'(done), 32'd0);
   endtask

   function automatic int jpoll(input int dl);
      return (dl + GAP - 1) / GAP;
   endfunction

   // ---------------- scenarios ----------------
   task automatic t_reset;
      chk(req_ready == 1'b1, "R2 ready after reset", 32'(req_ready), 32'd1);
      chk(phy_ctl == '0, "R1 word zero after reset", 32'(phy_ctl), 32'd0);
      chk(done == 1'b0, "R9 no done after reset", 32'(done), 32'd0);
      chk(err == 1'b0, "R8 err low after reset", 32'(err), 32'd0);
   endtask

   task automatic t_write_basic;
      int st, cyc;
      st = ntr;
      run(1'b1, 16'h0003, 16'hA5C3, cyc);
      chk(ntr - st == 9, "R5 write word count", 32'(ntr - st), 32'd9);
      chk_tr(st + 0, cw(4'b0000, 16'h0003), "R3 address, strobes low");
      chk_tr(st + 1, cw(4'b0001, 16'h0003), "R3 capture-address");
      chk_tr(st + 2, cw(4'b0000, 16'h0003), "R3 address held after capture");
      chk_tr(st + 3, cw(4'b0000, 16'hA5C3), "R4 data, strobes low");
      chk_tr(st + 4, cw(4'b0010, 16'hA5C3), "R4 capture-data");
      chk_tr(st + 5, cw(4'b0000, 16'hA5C3), "R4 data held after capture");
      chk_tr(st + 6, cw(4'b0100, 16'h0000), "R5 write strobe alone");
      chk_tr(st + 7, cw(4'b0000, 16'hA5C3), "R5 data after write strobe");
      chk_tr(st + 8, '0, "R5 word zero at end");
      chk(err == 1'b0, "R8 err low on success", 32'(err), 32'd0);
      chk(cyc == 3 * jpoll(dly) * GAP + 8, "R7 write latency", 32'(cyc),
          32'(3 * jpoll(dly) * GAP + 8));
   endtask

   task automatic t_read_basic;
      int st, cyc;
      st = ntr;
      run(1'b0, 16'h0003, 16'h7777, cyc);
      chk(ntr - st == 5, "R6 read word count", 32'(ntr - st), 32'd5);
      chk_tr(st + 0, cw(4'b0000, 16'h0003), "R3 read address");
      chk_tr(st + 1, cw(4'b0001, 16'h0003), "R3 read capture-address");
      chk_tr(st + 2, cw(4'b0000, 16'h0003), "R3 read address held");
      chk_tr(st + 3, cw(4'b1000, 16'h0000), "R6 read strobe alone");
      chk_tr(st + 4, '0, "R6 word zero after read");
      chk(rd_data == 16'hA5C3, "R6 read data", 32'(rd_data), 32'hA5C3);
      chk(err == 1'b0, "R8 err low on read", 32'(err), 32'd0);
      chk(cyc == 2 * jpoll(dly) * GAP + 5, "R7 read latency", 32'(cyc),
          32'(2 * jpoll(dly) * GAP + 5));
   endtask

   task automatic t_busy_ignored;
      int d0, cyc;
      d0 = n_done;
      @(negedge clk);
      req_write = 1'b1; req_addr = 16'h0005; req_wdata = 16'h5A5A; req_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0; req_addr = 16'h0004; req_wdata = 16'hFFFF;
      repeat (3) @(negedge clk);
      chk(req_ready == 1'b0, "R2 not ready while busy", 32'(req_ready), 32'd0);
      req_write = 1'b1; req_addr = 16'h0006; req_wdata = 16'h6666; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      cyc = 0;
      while (!done && cyc < 3000) begin @(negedge clk); cyc++; end
      repeat (6) @(negedge clk);
      chk(n_done - d0 == 1, "R9 one done per accepted request", 32'(n_done - d0), 32'd1);
      chk(req_ready == 1'b1, "R2 ready again", 32'(req_ready), 32'd1);
      run(1'b0, 16'h0006, 16'h0000, cyc);
      chk(rd_data == 16'h0000, "R2 busy request had no effect", 32'(rd_data), 32'd0);
      run(1'b0, 16'h0005, 16'h0000, cyc);
      chk(rd_data == 16'h5A5A, "R2 registered inputs used", 32'(rd_data), 32'h5A5A);
   endtask

   task automatic t_spacing;
      int cyc;
      dly = 5;
      run(1'b1, 16'h0002, 16'h1357, cyc);
      chk(cyc == 3 * jpoll(5) * GAP + 8, "R7 poll spacing on write", 32'(cyc),
          32'(3 * jpoll(5) * GAP + 8));
      dly = 0;
      run(1'b0, 16'h0002, 16'h0000, cyc);
      chk(cyc == 5, "R7 first-cycle sample hit", 32'(cyc), 32'd5);
      chk(rd_data == 16'h1357, "R6 read after spaced write", 32'(rd_data), 32'h1357);
      dly = 2;
   endtask

   task automatic t_last_sample;
      int cyc;
      dly = (MAXP - 1) * GAP;
      run(1'b0, 16'h0002, 16'h0000, cyc);
      chk(err == 1'b0, "R7 ack on last sample succeeds", 32'(err), 32'd0);
      chk(cyc == 2 * (MAXP - 1) * GAP + 5, "R7 last-sample latency", 32'(cyc),
          32'(2 * (MAXP - 1) * GAP + 5));
      dly = (MAXP - 1) * GAP + 1;
      run(1'b0, 16'h0002, 16'h0000, cyc);
      chk(err == 1'b1, "R8 ack one cycle late times out", 32'(err), 32'd1);
      chk(cyc == (MAXP - 1) * GAP + 2, "R8 timeout latency", 32'(cyc),
          32'((MAXP - 1) * GAP + 2));
      dly = 2;
   endtask

   task automatic t_stuck_low;
      int st, cyc;
      force_lo = 1'b1;
      st = ntr;
      run(1'b1, 16'h0007, 16'h1234, cyc);
      force_lo = 1'b0;
      chk(err == 1'b1, "R8 stuck-low err", 32'(err), 32'd1);
      chk(cyc == (MAXP - 1) * GAP + 2, "R8 stuck-low latency", 32'(cyc),
          32'((MAXP - 1) * GAP + 2));
      chk(ntr - st == 3, "R8 later phases skipped", 32'(ntr - st), 32'd3);
      chk_tr(st + 2, '0, "R8 word zero on timeout");
      chk(req_ready == 1'b1, "R8 ready after timeout", 32'(req_ready), 32'd1);
      run(1'b0, 16'h0007, 16'h0000, cyc);
      chk(rd_data == 16'h0000, "R8 aborted write left register", 32'(rd_data), 32'd0);
      chk(err == 1'b0, "R8 err cleared by next access", 32'(err), 32'd0);
   endtask

   task automatic t_stuck_high;
      int st, cyc;
      logic [DW-1:0] keep;
      keep = rd_data;
      force_hi = 1'b1;
      st = ntr;
      run(1'b0, 16'h0003, 16'h0000, cyc);
      force_hi = 1'b0;
      chk(err == 1'b1, "R8 release wait timeout", 32'(err), 32'd1);
      chk(cyc == (MAXP - 1) * GAP + 3, "R8 release timeout latency", 32'(cyc),
          32'((MAXP - 1) * GAP + 3));
      chk(ntr - st == 4, "R8 read strobe never raised", 32'(ntr - st), 32'd4);
      chk(rd_data == keep, "R9 rd_data kept on failed read", 32'(rd_data), 32'(keep));
   endtask

   task automatic t_hold;
      int cyc;
      run(1'b0, 16'h0003, 16'h0000, cyc);
      run(1'b1, 16'h0001, 16'hBEEF, cyc);
      chk(rd_data == 16'hA5C3, "R9 rd_data held across write", 32'(rd_data), 32'hA5C3);
   endtask

   task automatic t_strobe_scan;
      int bad;
      bad = 0;
      for (int i = 0; i < ntr && i < 256; i++) begin
         if ($countones(trace[i][CW-1:DW]) > 1) bad++;
      end
      chk(bad == 0, "R1 at most one strobe in every word", 32'(bad), 32'd0);
      chk(phy_ctl == '0, "R1 word zero in idle", 32'(phy_ctl), 32'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_write_basic();
      t_read_basic();
      t_busy_ignored();
      t_spacing();
      t_last_sample();
      t_stuck_low();
      t_stuck_high();
      t_hold();
      t_strobe_scan();
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end

endmodule